// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block manages the low-power states of a four-channel data converter. Two states are available. A whole-device sleep turns off every channel core and also the shared reference and PLL circuits. A per-channel nap turns off any chosen subset of channel cores and leaves the shared circuits running. The block drives one power enable for each channel core and one for the shared circuits. It also drives one ready flag for each channel. A ready flag rises only after that channel's recovery interval has passed.

The two states recover at different speeds, and the block counts each with a different timebase. Recovery from nap is counted in sample-clock cycles. An optional settle period can be added after it, counted in ticks of a slow timebase. Recovery from sleep is counted in slow-timebase ticks only. The tick is an input, so all timed intervals are independent of the sample-clock frequency. With the defaults, one tick is one microsecond: the sleep recovery is 2000 ticks and the settle period is 50 ticks.

The block has two control sources. In register mode, a sleep bit, a nap mask and a settle-enable bit come from a control register. In strapped mode, a single pin requests sleep, and nap is not available.

Top module: `conv_pwr_seq`

## Requirements
- R1: After reset, `shared_pwr_en` is 1, every `ch_pwr_en` bit is 1, and every `ch_ready` bit is 1 (all control inputs low).
- R2: The sleep request is `reg_sleep` in register mode (`pin_mode`=0) and `pin_sleep` in strapped mode (`pin_mode`=1). On the rising edge that samples the sleep request high, `shared_pwr_en`, all `ch_pwr_en` bits and all `ch_ready` bits go to 0.
- R3: Sleep has priority over nap. While the device is asleep or recovering from sleep, every `ch_ready` bit is 0, whatever the nap mask holds.
- R4: On the edge that samples the sleep request low, `shared_pwr_en` returns to 1, together with `ch_pwr_en` of each channel that is not napped. The `ch_ready` flags stay 0 until the edge that samples the SLEEP_WAKE_TICKS-th `tick` pulse after that point.
- R5: On the edge that samples `reg_nap[i]`=1 in register mode, `ch_pwr_en[i]` and `ch_ready[i]` go to 0. The other channels and `shared_pwr_en` keep their values.
- R6: On the edge that samples `reg_nap[i]` low, `ch_pwr_en[i]` returns to 1. With `reg_settle_en`=0, `ch_ready[i]` stays 0 for exactly NAP_WAKE_CYC clock cycles and then rises.
- R7: With `reg_settle_en`=1, `ch_ready[i]` stays 0 after the NAP_WAKE_CYC interval. It rises on the edge that samples the SETTLE_TICKS-th `tick` pulse counted after that interval.
- R8: If `reg_nap[i]` returns high during a nap recovery, the recovery is cancelled and `ch_pwr_en[i]` goes to 0. The next recovery counts the full NAP_WAKE_CYC interval again from the start.
- R9: In strapped mode, `reg_sleep` and `reg_nap` have no effect: all power enables and ready flags stay 1 while both are high.
- R10: Clock cycles without a `tick` pulse do not advance the sleep-recovery or settle intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| pin_mode | input | 1 | 1 = strapped control, 0 = register control |
| pin_sleep | input | 1 | Sleep request pin (strapped mode) |
| reg_sleep | input | 1 | Sleep request bit (register mode) |
| reg_nap | input | NCH | Per-channel nap mask (register mode) |
| reg_settle_en | input | 1 | Adds the settle period after nap recovery |
| shared_pwr_en | output | 1 | Power enable for the shared reference and PLL |
| ch_pwr_en | output | NCH | Power enable for each channel core |
| ch_ready | output | NCH | Ready flag for each channel |

## Verification
The bench builds the block with NAP_WAKE_CYC=12, SETTLE_TICKS=3 and SLEEP_WAKE_TICKS=6. With these values, each recovery window is short enough to step through edge by edge, and the bench checks the ready flag on both sides of the edge where it rises. The settle length is above zero, so the variant that has the settle stage is the one elaborated. The clock interval of 12 cycles is long enough that a nap recovery cancelled after five cycles would finish early if the counter were not cleared. The bench also lets a nap recovery finish while the device is still recovering from sleep, which checks that sleep keeps priority over nap.

// File: rtl/conv_pwr_pkg.sv
package conv_pwr_pkg;
   typedef enum logic [1:0] {
      CHIP_ON   = 2'd0,
      CHIP_OFF  = 2'd1,
      CHIP_WAKE = 2'd2
   } chip_state_e;

   typedef enum logic [1:0] {
      CH_RDY    = 2'd0,
      CH_NAP    = 2'd1,
      CH_WAKE   = 2'd2,
      CH_SETTLE = 2'd3
   } ch_state_e;
endpackage

// File: rtl/conv_pwr_sleep_ctrl.sv
module conv_pwr_sleep_ctrl
   import conv_pwr_pkg::*;
#(
   parameter int WAKE_TICKS = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sleep_req,
   output logic shared_on,
   output logic chip_ok
);
   localparam int TW = $clog2(WAKE_TICKS + 1);
   localparam logic [TW-1:0] LAST = TW'(WAKE_TICKS - 1);

   chip_state_e   st;
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= CHIP_ON;
         tcnt <= '0;
      end else if (sleep_req) begin
         st   <= CHIP_OFF;
         tcnt <= '0;
      end else begin
         case (st)
            CHIP_OFF: begin
               st   <= CHIP_WAKE;
               tcnt <= '0;
            end
            CHIP_WAKE: begin
               if (tick) begin
                  if (tcnt == LAST) begin
                     st   <= CHIP_ON;
                     tcnt <= '0;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign shared_on = (st != CHIP_OFF);
   assign chip_ok   = (st == CHIP_ON);

   // R2
   sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> !shared_on && !chip_ok);

   // R10
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CHIP_WAKE && !tick) |=> !chip_ok);
endmodule

// File: rtl/conv_pwr_nap_chan.sv
module conv_pwr_nap_chan
   import conv_pwr_pkg::*;
#(
   parameter int WAKE_CYC     = 100,
   parameter int SETTLE_TICKS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic nap_req,
   input  logic settle_en,
   input  logic shared_on,
   input  logic chip_ok,
   output logic pwr_en,
   output logic ready
);
   localparam int CMAX = (WAKE_CYC > SETTLE_TICKS) ? WAKE_CYC : SETTLE_TICKS;
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] WAKE_LAST   = CW'(WAKE_CYC - 1);
   localparam logic [CW-1:0] SETTLE_LAST = CW'((SETTLE_TICKS > 0) ? SETTLE_TICKS - 1 : 0);

   ch_state_e     st;
   logic [CW-1:0] cnt;
   logic          settle_go;

   generate
      if (SETTLE_TICKS > 0) begin : g_settle
         assign settle_go = settle_en;
      end else begin : g_no_settle
         assign settle_go = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= CH_RDY;
         cnt <= '0;
      end else if (nap_req) begin
         st  <= CH_NAP;
         cnt <= '0;
      end else begin
         case (st)
            CH_NAP: begin
               st  <= CH_WAKE;
               cnt <= '0;
            end
            CH_WAKE: begin
               if (cnt == WAKE_LAST) begin
                  st  <= settle_go ? CH_SETTLE : CH_RDY;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            CH_SETTLE: begin
               if (tick) begin
                  if (cnt == SETTLE_LAST) begin
                     st  <= CH_RDY;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign pwr_en = shared_on && (st != CH_NAP);
   assign ready  = chip_ok && (st == CH_RDY);

   // R5
   nap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nap_req |=> !pwr_en && !ready);

   // R8
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_WAKE && nap_req) |=> (st == CH_NAP) && (cnt == '0));

   // R7
   settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_SETTLE && !tick && !nap_req) |=> !ready);
endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
   import conv_pwr_pkg::*;
#(
   parameter int NCH              = 4,
   parameter int NAP_WAKE_CYC     = 100,
   parameter int SETTLE_TICKS     = 50,
   parameter int SLEEP_WAKE_TICKS = 2000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           pin_mode,
   input  logic           pin_sleep,
   input  logic           reg_sleep,
   input  logic [NCH-1:0] reg_nap,
   input  logic           reg_settle_en,
   output logic           shared_pwr_en,
   output logic [NCH-1:0] ch_pwr_en,
   output logic [NCH-1:0] ch_ready
);
   initial begin
      nch_range_chk: assert (NCH >= 1);
      nap_cyc_chk: assert (NAP_WAKE_CYC >= 1);
      settle_chk: assert (SETTLE_TICKS >= 0);
      sleep_ticks_chk: assert (SLEEP_WAKE_TICKS >= 1);
   end

   logic           sleep_req;
   logic [NCH-1:0] nap_req;
   logic           chip_ok;

   assign sleep_req = pin_mode ? pin_sleep : reg_sleep;
   assign nap_req   = pin_mode ? '0 : reg_nap;

   conv_pwr_sleep_ctrl #(
      .WAKE_TICKS(SLEEP_WAKE_TICKS)
   ) u_sleep (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sleep_req(sleep_req),
      .shared_on(shared_pwr_en),
      .chip_ok  (chip_ok)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         conv_pwr_nap_chan #(
            .WAKE_CYC    (NAP_WAKE_CYC),
            .SETTLE_TICKS(SETTLE_TICKS)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .nap_req  (nap_req[i]),
            .settle_en(reg_settle_en),
            .shared_on(shared_pwr_en),
            .chip_ok  (chip_ok),
            .pwr_en   (ch_pwr_en[i]),
            .ready    (ch_ready[i])
         );
      end
   endgenerate

   // R2
   chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shared_pwr_en |-> (ch_pwr_en == '0));

   // R3
   sleep_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_ok |-> (ch_ready == '0));

   // R9
   strap_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode && !pin_sleep) |=> shared_pwr_en);
endmodule

// File: tb/conv_pwr_seq_tb.sv
module conv_pwr_seq_tb;
   localparam int NCH = 4;
   localparam int NW  = 12;
   localparam int ST  = 3;
   localparam int SW  = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick = 1'b0;
   logic           pin_mode = 1'b0;
   logic           pin_sleep = 1'b0;
   logic           reg_sleep = 1'b0;
   logic [NCH-1:0] reg_nap = '0;
   logic           reg_settle_en = 1'b0;
   logic           shared_pwr_en;
   logic [NCH-1:0] ch_pwr_en;
   logic [NCH-1:0] ch_ready;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   conv_pwr_seq #(
      .NCH(NCH), .NAP_WAKE_CYC(NW), .SETTLE_TICKS(ST), .SLEEP_WAKE_TICKS(SW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin_mode(pin_mode),
      .pin_sleep(pin_sleep), .reg_sleep(reg_sleep), .reg_nap(reg_nap),
      .reg_settle_en(reg_settle_en), .shared_pwr_en(shared_pwr_en),
      .ch_pwr_en(ch_pwr_en), .ch_ready(ch_ready)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1;
         step(1);
         tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      check("R1 shared", 32'(shared_pwr_en), 32'h1);
      check("R1 pwr", 32'(ch_pwr_en), 32'hF);
      check("R1 ready", 32'(ch_ready), 32'hF);
   endtask

   task automatic t_nap();
      reg_nap = 4'b0101;
      step(1);
      check("R5 pwr", 32'(ch_pwr_en), 32'hA);
      check("R5 ready", 32'(ch_ready), 32'hA);
      check("R5 shared", 32'(shared_pwr_en), 32'h1);
      reg_nap = '0;
      step(1);
      check("R6 pwr back", 32'(ch_pwr_en), 32'hF);
      check("R6 ready low", 32'(ch_ready), 32'hA);
      step(NW - 1);
      check("R6 ready before", 32'(ch_ready), 32'hA);
      step(1);
      check("R6 ready rise", 32'(ch_ready), 32'hF);
   endtask

   task automatic t_settle();
      reg_settle_en = 1'b1;
      reg_nap = 4'b0010;
      step(1);
      reg_nap = '0;
      step(1);
      step(NW);
      check("R7 after clocks", 32'(ch_ready), 32'hD);
      check("R7 powered", 32'(ch_pwr_en), 32'hF);
      step(5);
      check("R10 idle settle", 32'(ch_ready), 32'hD);
      pulse_ticks(ST - 1);
      check("R7 before last tick", 32'(ch_ready), 32'hD);
      pulse_ticks(1);
      check("R7 ready", 32'(ch_ready), 32'hF);
      reg_settle_en = 1'b0;
   endtask

   task automatic t_cancel();
      reg_nap = 4'b1000;
      step(1);
      reg_nap = '0;
      step(5);
      reg_nap = 4'b1000;
      step(1);
      check("R8 pwr off", 32'(ch_pwr_en), 32'h7);
      reg_nap = '0;
      step(1);
      step(NW - 1);
      check("R8 full restart", 32'(ch_ready), 32'h7);
      step(1);
      check("R8 ready", 32'(ch_ready), 32'hF);
   endtask

   task automatic t_sleep();
      reg_sleep = 1'b1;
      reg_nap = 4'b0001;
      step(1);
      check("R2 shared", 32'(shared_pwr_en), 32'h0);
      check("R2 pwr", 32'(ch_pwr_en), 32'h0);
      check("R2 ready", 32'(ch_ready), 32'h0);
      reg_nap = '0;
      step(3);
      check("R3 nap cleared", 32'(ch_ready), 32'h0);
      reg_sleep = 1'b0;
      step(1);
      check("R4 shared back", 32'(shared_pwr_en), 32'h1);
      check("R4 pwr back", 32'(ch_pwr_en), 32'hF);
      check("R4 ready low", 32'(ch_ready), 32'h0);
      step(20);
      check("R10 no ticks", 32'(ch_ready), 32'h0);
      check("R3 nap done", 32'(ch_ready), 32'h0);
      pulse_ticks(SW - 1);
      check("R4 before last", 32'(ch_ready), 32'h0);
      pulse_ticks(1);
      check("R4 ready", 32'(ch_ready), 32'hF);
   endtask

   task automatic t_pin();
      pin_mode = 1'b1;
      reg_sleep = 1'b1;
      reg_nap = 4'hF;
      step(2);
      check("R9 shared", 32'(shared_pwr_en), 32'h1);
      check("R9 pwr", 32'(ch_pwr_en), 32'hF);
      check("R9 ready", 32'(ch_ready), 32'hF);
      pin_sleep = 1'b1;
      step(1);
      check("R2 pin sleep", 32'(shared_pwr_en), 32'h0);
      pin_sleep = 1'b0;
      step(1);
      pulse_ticks(SW);
      check("R4 pin wake", 32'(ch_ready), 32'hF);
      reg_sleep = 1'b0;
      reg_nap = '0;
      pin_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_nap();
      t_settle();
      t_cancel();
      t_sleep();
      t_pin();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule